// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block stands between a clock synthesizer and its output drivers. It owns the enables of the crystal oscillator and the VCO. It watches one shared control pin that has two meanings. Until the pin has been seen low once, it is an active-low "supply good" indication. After that it becomes an active-high request to power down. While the supply is not yet good, every output stays parked. Once the supply is good, a programmable window of reference cycles must pass before the outputs start. A power-down request that arrives inside that window keeps the outputs parked and turns the oscillator off, so power-down can be the first state the system sees.

A power-down request is first synchronized to the reference clock. It is accepted only when two consecutive synchronized samples are high. Each single-ended output is then held low from its next falling edge. Each differential pair parks when its complement side next falls, which is the same moment its true side rises. A per-pair mode bit picks the parked state: either true driven high with complement released, or both sides released. One cycle after every output reports parked, the oscillator and VCO enables drop. When the pin goes low again, the oscillator comes back first and the VCO one cycle later. After a stabilization count, all outputs are released on the same edge.

The input clocks are modelled as sampled waveforms on the reference clock. Each output follows its input one reference cycle later.

Top module: `clkpark_sequencer`

## Requirements
- R1: After reset, and for as long as the pin has not been sampled low, every output is parked and both `osc_en` and `vco_en` are 1. A high pin in this phase is not taken as power-down. Parked means: `se_out` is 0, `dif_c_oe` is 0, and `dif_t_oe` and `dif_t_out` both equal the inverse of that pair's mode bit.
- R2: If no power-down is seen in the start window, `all_parked` falls exactly SYNC_STAGES+1+INIT_WIN reference edges after the pin is first driven low.
- R3: While running, each `se_out` bit equals its `se_clk_in` bit as sampled at the previous edge. Each `dif_t_out` equals the sampled `dif_clk_in`, `dif_c_out` is its inverse, and both enables of every pair are 1.
- R4: A pin high for a single reference cycle while running has no effect.
- R5: Once power-down is accepted, each `se_out` bit falls only where its input was sampled low, and it stays 0 until release. No high pulse is cut short.
- R6: A pair with mode bit 0 parks with the true side driven 1 (`dif_t_oe`=1, `dif_t_out`=1) and `dif_c_oe`=0. It parks only on an edge where its input was sampled rising, and no later than 4 + one input period reference edges after the pin is raised.
- R7: A pair with mode bit 1 parks with `dif_t_oe`=0 and `dif_c_oe`=0.
- R8: `osc_en` and `vco_en` fall exactly one edge after `all_parked` rises, and they are never 0 while any output is unparked.
- R9: On release, `osc_en` returns SYNC_STAGES+1 edges after the pin falls and `vco_en` returns one edge later. All outputs unpark together, STAB_CYC edges after `osc_en` returns.
- R10: A power-down request raised inside the start window keeps every output parked, and the enables then fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pgpd | input | 1 | Shared pin: active-low supply-good, then active-high power-down request (asynchronous) |
| se_clk_in | input | N_SE | Single-ended source waveforms |
| dif_clk_in | input | N_DIF | Differential source waveforms (true phase) |
| dif_mode | input | N_DIF | Per-pair parked state: 0 = true driven high, 1 = both sides released |
| se_out | output | N_SE | Single-ended output data |
| dif_t_out | output | N_DIF | True-side output data |
| dif_t_oe | output | N_DIF | True-side output enable |
| dif_c_out | output | N_DIF | Complement-side output data |
| dif_c_oe | output | N_DIF | Complement-side output enable |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| all_parked | output | 1 | Every output is in its parked state |

## Verification
The hardest case to reach from the ports is a power-down request that lands inside the start window. The pin must fall, be seen as supply-good, and then rise again a few cycles later, before the window count runs out. The bench does this after a fresh reset and confirms that `all_parked` never drops. The other hard case is a set of lanes at different phases when parking begins. The input waveforms use unequal periods, so each lane waits a different number of edges. A monitor flags any cut-short pulse. The power-down and release cycle is repeated for all four mode-bit combinations.

// File: rtl/clkpark_pkg.sv
package clkpark_pkg;

   typedef enum logic [2:0] {
      ST_WAIT_PG = 3'd0,
      ST_WINDOW  = 3'd1,
      ST_RUN     = 3'd2,
      ST_PARK    = 3'd3,
      ST_OFF     = 3'd4,
      ST_WAKE    = 3'd5
   } seq_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkpark_sync.sv
module clkpark_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic pin_s,
   output logic pin_hi2
);
   logic [STAGES-1:0] sr;
   logic              held;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[0] <= 1'b1;
               else        sr[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[g] <= 1'b1;
               else        sr[g] <= sr[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b1;
      else        held <= sr[STAGES-1];
   end

   assign pin_s   = sr[STAGES-1];
   assign pin_hi2 = sr[STAGES-1] & held;
endmodule

// File: rtl/clkpark_ctrl.sv
module clkpark_ctrl
   import clkpark_pkg::*;
#(
   parameter int INIT_WIN = 8,
   parameter int STAB_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic pd_req,
   input  logic all_parked,
   output logic park_arm,
   output logic park_clear,
   output logic osc_en,
   output logic vco_en
);
   localparam int unsigned CNT_MAX = max2(INIT_WIN, STAB_CYC);
   localparam int          CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] WIN_LAST  = CW'(INIT_WIN - 1);
   localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);

   seq_state_t    state, state_n;
   logic [CW-1:0] cnt, cnt_n;

   always_comb begin
      state_n = state;
      cnt_n   = cnt;
      unique case (state)
         ST_WAIT_PG: begin
            if (!pin_s) begin
               state_n = ST_WINDOW;
               cnt_n   = '0;
            end
         end
         ST_WINDOW: begin
            if (pd_req)                state_n = ST_PARK;
            else if (cnt == WIN_LAST)  state_n = ST_RUN;
            else                       cnt_n   = cnt + 1'b1;
         end
         ST_RUN: begin
            if (pd_req) state_n = ST_PARK;
         end
         ST_PARK: begin
            if (all_parked) state_n = ST_OFF;
         end
         ST_OFF: begin
            if (!pin_s) begin
               state_n = ST_WAKE;
               cnt_n   = '0;
            end
         end
         ST_WAKE: begin
            if (cnt == STAB_LAST) state_n = ST_RUN;
            else                  cnt_n   = cnt + 1'b1;
         end
         default: state_n = ST_WAIT_PG;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_WAIT_PG;
         cnt   <= '0;
      end else begin
         state <= state_n;
         cnt   <= cnt_n;
      end
   end

   assign park_arm   = (state == ST_PARK);
   assign park_clear = ((state == ST_WINDOW) && !pd_req && (cnt == WIN_LAST)) ||
                       ((state == ST_WAKE) && (cnt == STAB_LAST));
   assign osc_en     = (state != ST_OFF);
   assign vco_en     = (state != ST_OFF) && !((state == ST_WAKE) && (cnt == '0));
endmodule

// File: rtl/clkpark_se_lane.sv
module clkpark_se_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_in,
   input  logic arm,
   input  logic clear,
   output logic out,
   output logic parked
);
   logic q;
   logic set_park;
   logic parked_n;

   // park on a sampled falling edge of the source
   assign set_park = arm & q & ~clk_in;
   assign parked_n = (parked & ~clear) | set_park;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= 1'b0;
         parked <= 1'b1;
      end else begin
         parked <= parked_n;
         q      <= parked_n ? 1'b0 : clk_in;
      end
   end

   assign out = q;
endmodule

// File: rtl/clkpark_dif_lane.sv
module clkpark_dif_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_in,
   input  logic mode,
   input  logic arm,
   input  logic clear,
   output logic t_out,
   output logic t_oe,
   output logic c_out,
   output logic c_oe,
   output logic parked
);
   logic q;
   logic set_park;

   // complement falls where the true phase rises
   assign set_park = arm & ~q & clk_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= 1'b0;
         parked <= 1'b1;
      end else begin
         q      <= clk_in;
         parked <= (parked & ~clear) | set_park;
      end
   end

   assign t_out = parked ? ~mode : q;
   assign t_oe  = parked ? ~mode : 1'b1;
   assign c_out = parked ? 1'b0 : ~q;
   assign c_oe  = ~parked;
endmodule

// File: rtl/clkpark_sequencer.sv
module clkpark_sequencer #(
   parameter int N_SE        = 2,
   parameter int N_DIF       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int INIT_WIN    = 8,
   parameter int STAB_CYC    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_pgpd,
   input  logic [N_SE-1:0]  se_clk_in,
   input  logic [N_DIF-1:0] dif_clk_in,
   input  logic [N_DIF-1:0] dif_mode,
   output logic [N_SE-1:0]  se_out,
   output logic [N_DIF-1:0] dif_t_out,
   output logic [N_DIF-1:0] dif_t_oe,
   output logic [N_DIF-1:0] dif_c_out,
   output logic [N_DIF-1:0] dif_c_oe,
   output logic             osc_en,
   output logic             vco_en,
   output logic             all_parked
);
   localparam int N_LANES = N_SE + N_DIF;

   generate
      if (N_SE < 1)        begin : g_bad_se   $error("N_SE must be at least 1");        end
      if (N_DIF < 1)       begin : g_bad_dif  $error("N_DIF must be at least 1");       end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (INIT_WIN < 1)    begin : g_bad_win  $error("INIT_WIN must be at least 1");    end
      if (STAB_CYC < 1)    begin : g_bad_stab $error("STAB_CYC must be at least 1");    end
   endgenerate

   logic               pin_s;
   logic               pd_req;
   logic               park_arm;
   logic               park_clear;
   logic [N_LANES-1:0] lane_parked;

   clkpark_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pin_pgpd),
      .pin_s   (pin_s),
      .pin_hi2 (pd_req)
   );

   clkpark_ctrl #(.INIT_WIN(INIT_WIN), .STAB_CYC(STAB_CYC)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (pin_s),
      .pd_req     (pd_req),
      .all_parked (all_parked),
      .park_arm   (park_arm),
      .park_clear (park_clear),
      .osc_en     (osc_en),
      .vco_en     (vco_en)
   );

   generate
      for (genvar i = 0; i < N_SE; i++) begin : g_se
         clkpark_se_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clk_in (se_clk_in[i]),
            .arm    (park_arm),
            .clear  (park_clear),
            .out    (se_out[i]),
            .parked (lane_parked[i])
         );
      end
      for (genvar j = 0; j < N_DIF; j++) begin : g_dif
         clkpark_dif_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clk_in (dif_clk_in[j]),
            .mode   (dif_mode[j]),
            .arm    (park_arm),
            .clear  (park_clear),
            .t_out  (dif_t_out[j]),
            .t_oe   (dif_t_oe[j]),
            .c_out  (dif_c_out[j]),
            .c_oe   (dif_c_oe[j]),
            .parked (lane_parked[N_SE+j])
         );
      end
   endgenerate

   assign all_parked = &lane_parked;
endmodule

// File: rtl/clkpark_checker.sv
module clkpark_checker #(
   parameter int N_SE  = 2,
   parameter int N_DIF = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SE-1:0]  se_out,
   input logic [N_DIF-1:0] dif_mode,
   input logic [N_DIF-1:0] dif_t_out,
   input logic [N_DIF-1:0] dif_t_oe,
   input logic [N_DIF-1:0] dif_c_oe,
   input logic             osc_en,
   input logic             vco_en,
   input logic             all_parked
);
   // R8
   osc_off_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en || !vco_en) |-> all_parked);

   // R8
   osc_fall_after_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en) |-> $past(all_parked));

   // R9
   unpark_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|dif_c_oe) |-> (&dif_c_oe));

   // R9
   unpark_enables_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(all_parked) |-> (osc_en && vco_en));

   // R5
   se_low_when_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_parked |-> (se_out == '0));

   generate
      for (genvar k = 0; k < N_DIF; k++) begin : g_pair
         // R6
         mode0_true_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!dif_c_oe[k] && !dif_mode[k]) |-> (dif_t_oe[k] && dif_t_out[k]));
         // R7
         true_off_implies_comp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dif_t_oe[k] |-> !dif_c_oe[k]);
      end
   endgenerate
endmodule

bind clkpark_sequencer clkpark_checker #(.N_SE(N_SE), .N_DIF(N_DIF)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .se_out     (se_out),
   .dif_mode   (dif_mode),
   .dif_t_out  (dif_t_out),
   .dif_t_oe   (dif_t_oe),
   .dif_c_oe   (dif_c_oe),
   .osc_en     (osc_en),
   .vco_en     (vco_en),
   .all_parked (all_parked)
);

// File: tb/clkpark_sequencer_test.sv
`timescale 1ns/1ps
module clkpark_sequencer_test;
   localparam int N_SE = 2, N_DIF = 2, SYNC = 2, WIN = 8, STAB = 16;
   localparam int START_LAT = SYNC + 1 + WIN;
   localparam int WAKE_LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin = 1'b1;
   logic [N_SE-1:0]  se_in = '0;
   logic [N_DIF-1:0] dif_in = '0;
   logic [N_DIF-1:0] mode = '0;
   logic [N_SE-1:0]  se_out;
   logic [N_DIF-1:0] t_out, t_oe, c_out, c_oe;
   logic osc_en, vco_en, all_parked;

   int errors = 0, checks = 0, edge_n = 0, tc = 0;
   int glitch_se = 0, glitch_dif = 0;
   logic [N_SE-1:0]  samp_se = '0, prev_se_out = '0;
   logic [N_DIF-1:0] samp_dif = '0, prev_c_oe = '0;
   int se_per [N_SE]  = '{3, 5};
   int dif_per[N_DIF] = '{2, 3};

   always #5 clk = ~clk;

   clkpark_sequencer #(.N_SE(N_SE), .N_DIF(N_DIF), .SYNC_STAGES(SYNC),
                       .INIT_WIN(WIN), .STAB_CYC(STAB)) uut (
      .clk(clk), .rst_n(rst_n), .pin_pgpd(pin), .se_clk_in(se_in),
      .dif_clk_in(dif_in), .dif_mode(mode), .se_out(se_out),
      .dif_t_out(t_out), .dif_t_oe(t_oe), .dif_c_out(c_out), .dif_c_oe(c_oe),
      .osc_en(osc_en), .vco_en(vco_en), .all_parked(all_parked));

   // source waveforms, changed away from the active edge
   initial forever begin
      @(negedge clk);
      tc++;
      for (int i = 0; i < N_SE; i++)  se_in[i]  = ((tc / se_per[i]) % 2) == 1;
      for (int j = 0; j < N_DIF; j++) dif_in[j] = ((tc / dif_per[j]) % 2) == 1;
   end

   // edge monitor: records inputs as sampled and watches for cut-short pulses
   initial forever begin
      @(posedge clk);
      #1;
      edge_n++;
      for (int i = 0; i < N_SE; i++)
         if (rst_n && prev_se_out[i] && !se_out[i] && se_in[i]) glitch_se++;
      for (int j = 0; j < N_DIF; j++)
         if (rst_n && prev_c_oe[j] && !c_oe[j] && !(dif_in[j] && !samp_dif[j])) glitch_dif++;
      samp_se = se_in;
      samp_dif = dif_in;
      prev_se_out = se_out;
      prev_c_oe = c_oe;
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finish_run();
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pin = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
   endtask

   task automatic check_parked_state(input string req);
      chk(se_out == '0, req, "se_out parked", se_out, 0);
      chk(c_oe == '0, req, "c_oe parked", c_oe, 0);
      chk(t_oe == ~mode, req, "t_oe parked", t_oe, ~mode);
      chk((t_out & ~mode) == ~mode, req, "t_out parked", t_out, ~mode);
   endtask

   task automatic powerdown_cycle(input logic [N_DIF-1:0] m);
      int pin_edge, park_edge;
      int dpark[N_DIF];
      @(negedge clk);
      mode = m;
      pin = 1'b1;
      pin_edge = edge_n;
      for (int j = 0; j < N_DIF; j++) dpark[j] = -1;
      park_edge = -1;
      for (int k = 0; k < 80 && park_edge < 0; k++) begin
         step();
         for (int j = 0; j < N_DIF; j++)
            if (dpark[j] < 0 && !c_oe[j]) dpark[j] = edge_n;
         if (all_parked) park_edge = edge_n;
         else chk(osc_en && vco_en, "R8", "enables on while unparked", osc_en, 1);
      end
      chk(park_edge >= 0, "R5", "all outputs parked", all_parked, 1);
      for (int j = 0; j < N_DIF; j++)
         chk(dpark[j] >= 0 && dpark[j] - pin_edge <= 4 + 2 * dif_per[j], "R6",
             "pair park latency", dpark[j] - pin_edge, 4 + 2 * dif_per[j]);
      chk(osc_en == 1'b1, "R8", "osc still on at park edge", osc_en, 1);
      check_parked_state(m[0] ? "R7" : "R6");
      step();
      chk(!osc_en && !vco_en, "R8", "enables off one edge after park", {osc_en, vco_en}, 0);
      for (int k = 0; k < 12; k++) step();
      chk(se_out == '0 && all_parked, "R5", "held low while off", se_out, 0);
      // release
      @(negedge clk);
      pin = 1'b0;
      for (int k = 1; k <= WAKE_LAT + STAB; k++) begin
         step();
         if (k == WAKE_LAT - 1) chk(!osc_en, "R9", "osc not early", osc_en, 0);
         if (k == WAKE_LAT) chk(osc_en && !vco_en, "R9", "osc first", {osc_en, vco_en}, 2);
         if (k == WAKE_LAT + 1) chk(vco_en, "R9", "vco one edge later", vco_en, 1);
         if (k == WAKE_LAT + STAB - 1) chk(all_parked, "R9", "still parked", all_parked, 1);
         if (k == WAKE_LAT + STAB)
            chk(!all_parked && c_oe == '1, "R9", "all unpark together", c_oe, 3);
      end
      for (int k = 0; k < 8; k++) step();
   endtask

   initial begin
      mode = 2'b10;
      do_reset();
      // R1 reset state
      chk(all_parked, "R1", "parked after reset", all_parked, 1);
      chk(osc_en && vco_en, "R1", "enables on after reset", {osc_en, vco_en}, 3);
      check_parked_state("R1");
      for (int k = 0; k < 30; k++) step();
      chk(all_parked && osc_en, "R1", "high pin before supply-good ignored", all_parked, 1);

      // R2 start window
      @(negedge clk);
      pin = 1'b0;
      for (int k = 1; k <= START_LAT; k++) begin
         step();
         if (k == START_LAT - 1) chk(all_parked, "R2", "parked before window end", all_parked, 1);
         if (k == START_LAT) chk(!all_parked, "R2", "released at window end", all_parked, 0);
      end

      // R3 running follow
      for (int k = 0; k < 24; k++) begin
         step();
         chk(se_out == samp_se, "R3", "se_out follows", se_out, samp_se);
         chk(t_out == samp_dif && c_out == ~samp_dif && t_oe == '1 && c_oe == '1,
             "R3", "pair follows", t_out, samp_dif);
      end

      // R4 one-cycle pulse
      @(negedge clk); pin = 1'b1;
      @(negedge clk); pin = 1'b0;
      for (int k = 0; k < 10; k++) step();
      chk(!all_parked && osc_en && vco_en, "R4", "short pulse ignored", all_parked, 0);

      // R5..R9 over every mode combination
      for (int m = 0; m < 4; m++) powerdown_cycle(2'(m));
      chk(glitch_se == 0, "R5", "no cut-short single-ended pulse", glitch_se, 0);
      chk(glitch_dif == 0, "R6", "pairs park on rising true", glitch_dif, 0);

      // R10 power-down inside start window
      begin
         bit dropped = 0;
         mode = 2'b01;
         do_reset();
         for (int k = 0; k < 5; k++) step();
         @(negedge clk); pin = 1'b0;
         for (int k = 0; k < 4; k++) begin
            step();
            if (!all_parked) dropped = 1;
         end
         @(negedge clk); pin = 1'b1;
         for (int k = 0; k < 40; k++) begin
            step();
            if (!all_parked) dropped = 1;
         end
         chk(!dropped, "R10", "outputs never started", dropped, 0);
         chk(!osc_en && !vco_en, "R10", "enables off", {osc_en, vco_en}, 0);
         check_parked_state("R10");
      end
      finish_run();
   end
endmodule